// File: doc/BRIEF.md
# Variable-Length DMA Channel Engine

This block is one channel of a DMA engine. Software loads a configuration, and the block then copies units from a source region to a destination region through a plain memory read port and a plain memory write port. The configuration covers the start addresses, a length, the unit size (8 or 16 bits), how each address steps, the transfer mode, whether the length comes from the data, and whether completion raises an interrupt.

An `arm` pulse latches the configuration and arms the channel. Each `trig` pulse then starts work. In the single modes a trigger moves one unit. In the block modes a trigger moves the whole count. When the count is reached, the repeated modes restart from the latched start addresses and stay armed, and the other modes disarm.

In variable-length mode the first unit read at the source carries the count. The count is first extracted from that unit, then adjusted by one of four counting variants, then capped by the configured length. Arbitration against other requesters is not part of this block. Neither is decoding of a register file or selection of trigger sources.

Top module: `vlen_dma_chan`

## Requirements
- R1: After reset `armed`, `irq`, `mem_rd_en` and `mem_wr_en` are 0. An `arm` pulse while the channel is idle or waiting latches every `cfg_*` input and sets `armed`.
- R2: In single (`cfg_mode`=00) and repeated single (10), each accepted trigger writes exactly one unit. The run completes when the count is reached.
- R3: In block (01) and repeated block (11), one trigger writes the whole count back to back. A trigger that arrives while a block is running is ignored.
- R4: Each address steps by its own 2-bit code: 00 hold, 01 increment, 10 decrement, 11 hold. The stride is 1 for byte units and 2 for word units.
- R5: `cfg_word`=1 selects 16-bit units and `cfg_word`=0 selects 8-bit units. `mem_wr_word` follows the latched size, and byte data sits in bits 7:0. Memory is little-endian, so a word at address a has its low byte at a.
- R6: Repeated modes stay armed after completion and restart from the latched start addresses, the latched length and the latched length-prefix setting. Non-repeated modes drop `armed`.
- R7: Completion pulses `irq` high for one cycle, in the cycle after the final write or the completing trigger. This happens only if `cfg_irq_en` was 1 when the channel was armed.
- R8: With `cfg_vlen`=1 the first source unit gives N, and the total number of units written is set by `cfg_vlen_opt`. Option 00 gives N+1, with the prefix written first. Option 01 gives N, with the prefix read but not written and copying starting at the next source unit. Option 10 gives N+2 and option 11 gives N+3, both with the prefix written first.
- R9: In byte mode, `cfg_m8`=1 takes N from all 8 bits of the prefix and `cfg_m8`=0 takes N from bits 6:0 only. In word mode, N is bits 12:0 of the prefix and `cfg_m8` has no effect.
- R10: In variable-length mode the total number of units written never exceeds `cfg_len`.
- R11: A total of zero completes with no write at all and still raises `irq` when it is enabled. This covers a fixed length of 0, and a variable length that works out to 0.
- R12: A trigger while the channel is disarmed causes no memory access. An `arm` pulse while a transfer is in progress is ignored.
- R13: A unit is read in one cycle (`mem_rd_en`, `mem_rd_addr`). It is written in the next cycle (`mem_wr_en`, `mem_wr_addr`), with `mem_wr_data` taken from `mem_rd_data`, which the memory returns one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Latch configuration and arm the channel |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_len | input | LEN_W | Fixed length, or the cap in variable-length mode |
| cfg_vlen | input | 1 | Take the count from the first source unit |
| cfg_vlen_opt | input | 2 | Counting variant for the length prefix |
| cfg_m8 | input | 1 | Use all 8 prefix bits in byte mode |
| cfg_word | input | 1 | 1 = 16-bit units, 0 = 8-bit units |
| cfg_src_step | input | 2 | Source address step code |
| cfg_dst_step | input | 2 | Destination address step code |
| cfg_mode | input | 2 | Transfer mode code |
| cfg_irq_en | input | 1 | Completion interrupt enable |
| trig | input | 1 | Trigger pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | 16 | Write data |
| mem_wr_word | output | 1 | Write is 16 bits wide |
| armed | output | 1 | Channel is armed |
| busy | output | 1 | A unit is being moved |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench sweeps both step codes, both unit sizes and the single and block modes. It then crosses every counting variant with prefixes that come out small, that reach the cap, and that carry high bits which must be masked away.

A design that mixed up option 01 with 00 would write the prefix, so the destination stream would shift by one unit. A design that ignored `cfg_m8` or the 13-bit word field would overrun to the cap.

Zero-length runs catch a design that writes one stray unit or loses the interrupt. A trigger during a block, and a re-arm carrying a different source, catch designs that start a second block or rewrite the addresses mid-flight. A second round in a repeated mode checks that the addresses restart rather than carry on.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   localparam int UNIT_W = 16;

   // address step codes
   localparam logic [1:0] STEP_HOLD = 2'b00;
   localparam logic [1:0] STEP_INC  = 2'b01;
   localparam logic [1:0] STEP_DEC  = 2'b10;

   // transfer modes: bit0 = block, bit1 = repeated
   localparam logic [1:0] XM_SINGLE  = 2'b00;
   localparam logic [1:0] XM_BLOCK   = 2'b01;
   localparam logic [1:0] XM_RSINGLE = 2'b10;
   localparam logic [1:0] XM_RBLOCK  = 2'b11;

   // length prefix counting variants
   localparam logic [1:0] VL_PFX_N  = 2'b00;
   localparam logic [1:0] VL_N      = 2'b01;
   localparam logic [1:0] VL_PFX_N1 = 2'b10;
   localparam logic [1:0] VL_PFX_N2 = 2'b11;

   typedef enum logic [1:0] {
      ST_OFF  = 2'b00,
      ST_WAIT = 2'b01,
      ST_RD   = 2'b10,
      ST_WR   = 2'b11
   } dmach_st_e;

endpackage

// File: rtl/dmach_step.sv
module dmach_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic [1:0]    mode,
   input  logic          word,
   output logic [AW-1:0] nxt
);
   import dmach_pkg::*;

   localparam logic [AW-1:0] STRIDE_B = AW'(1);
   localparam logic [AW-1:0] STRIDE_W = AW'(2);

   logic [AW-1:0] stride;

   always_comb begin
      stride = word ? STRIDE_W : STRIDE_B;
      case (mode)
         STEP_INC: nxt = ptr + stride;
         STEP_DEC: nxt = ptr - stride;
         default:  nxt = ptr;
      endcase
   end
endmodule

// File: rtl/dmach_lencalc.sv
module dmach_lencalc #(
   parameter int LEN_W   = 13,
   parameter bit VLEN_EN = 1'b1
) (
   input  logic [15:0]      unit,
   input  logic             word,
   input  logic             m8,
   input  logic [1:0]       opt,
   input  logic [LEN_W-1:0] cap,
   output logic [LEN_W-1:0] tot,
   output logic             keep
);
   import dmach_pkg::*;

   generate
      if (VLEN_EN) begin : g_vlen
         logic [15:0] n16;
         logic [15:0] add16;
         logic [15:0] raw;
         logic [15:0] cap16;

         always_comb begin
            if (word)    n16 = {3'b000, unit[12:0]};
            else if (m8) n16 = {8'h00, unit[7:0]};
            else         n16 = {9'h000, unit[6:0]};
            case (opt)
               VL_PFX_N:  add16 = 16'd1;
               VL_N:      add16 = 16'd0;
               VL_PFX_N1: add16 = 16'd2;
               default:   add16 = 16'd3;
            endcase
            raw   = n16 + add16;
            cap16 = 16'(cap);
            tot   = (raw > cap16) ? cap : raw[LEN_W-1:0];
            keep  = (opt != VL_N);
         end
      end else begin : g_fixed
         assign tot  = cap;
         assign keep = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/vlen_dma_chan.sv
module vlen_dma_chan #(
   parameter int AW      = 16,
   parameter int LEN_W   = 13,
   parameter bit VLEN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [AW-1:0]    cfg_src,
   input  logic [AW-1:0]    cfg_dst,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_vlen,
   input  logic [1:0]       cfg_vlen_opt,
   input  logic             cfg_m8,
   input  logic             cfg_word,
   input  logic [1:0]       cfg_src_step,
   input  logic [1:0]       cfg_dst_step,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_irq_en,
   input  logic             trig,
   output logic             mem_rd_en,
   output logic [AW-1:0]    mem_rd_addr,
   input  logic [15:0]      mem_rd_data,
   output logic             mem_wr_en,
   output logic [AW-1:0]    mem_wr_addr,
   output logic [15:0]      mem_wr_data,
   output logic             mem_wr_word,
   output logic             armed,
   output logic             busy,
   output logic             irq
);
   import dmach_pkg::*;

   localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_ZERO = '0;

   generate
      if (AW < 2 || AW > 32) begin : g_bad_aw
         $error("vlen_dma_chan: AW out of range");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("vlen_dma_chan: LEN_W out of range");
      end
   endgenerate

   // latched configuration
   logic [AW-1:0]    c_src0, c_dst0;
   logic [LEN_W-1:0] c_len;
   logic             c_vlen, c_m8, c_word, c_irqen;
   logic [1:0]       c_opt, c_sstep, c_dstep, c_mode;

   // run state
   dmach_st_e        st_q, st_d;
   logic [AW-1:0]    src_q, src_d, dst_q, dst_d;
   logic [LEN_W-1:0] rem_q, rem_d;
   logic             pfx_q, pfx_d;
   logic             irq_q;

   logic             load, done, do_wr;
   logic [AW-1:0]    src_nxt, dst_nxt;
   logic [LEN_W-1:0] vl_tot;
   logic             vl_keep;
   logic             is_blk, is_rpt;

   assign is_blk = c_mode[0];
   assign is_rpt = c_mode[1];

   dmach_step #(.AW(AW)) u_src_step (
      .ptr  (src_q),
      .mode (c_sstep),
      .word (c_word),
      .nxt  (src_nxt)
   );

   dmach_step #(.AW(AW)) u_dst_step (
      .ptr  (dst_q),
      .mode (c_dstep),
      .word (c_word),
      .nxt  (dst_nxt)
   );

   dmach_lencalc #(.LEN_W(LEN_W), .VLEN_EN(VLEN_EN)) u_len (
      .unit (mem_rd_data),
      .word (c_word),
      .m8   (c_m8),
      .opt  (c_opt),
      .cap  (c_len),
      .tot  (vl_tot),
      .keep (vl_keep)
   );

   always_comb begin
      st_d  = st_q;
      src_d = src_q;
      dst_d = dst_q;
      rem_d = rem_q;
      pfx_d = pfx_q;
      load  = 1'b0;
      done  = 1'b0;
      do_wr = 1'b0;
      case (st_q)
         ST_OFF: begin
            if (arm) load = 1'b1;
         end
         ST_WAIT: begin
            if (arm) begin
               load = 1'b1;
            end else if (trig) begin
               if (!pfx_q && rem_q == LEN_ZERO) done = 1'b1;
               else                             st_d = ST_RD;
            end
         end
         ST_RD: begin
            st_d = ST_WR;
         end
         default: begin
            src_d = src_nxt;
            if (pfx_q) begin
               pfx_d = 1'b0;
               if (vl_tot == LEN_ZERO) begin
                  done = 1'b1;
               end else if (vl_keep) begin
                  do_wr = 1'b1;
                  rem_d = vl_tot - LEN_ONE;
                  if (vl_tot == LEN_ONE) done = 1'b1;
                  else                   st_d = is_blk ? ST_RD : ST_WAIT;
               end else begin
                  rem_d = vl_tot;
                  st_d  = ST_RD;
               end
            end else begin
               do_wr = 1'b1;
               rem_d = rem_q - LEN_ONE;
               if (rem_q == LEN_ONE) done = 1'b1;
               else                  st_d = is_blk ? ST_RD : ST_WAIT;
            end
            if (do_wr) dst_d = dst_nxt;
         end
      endcase

      if (load) begin
         st_d  = ST_WAIT;
         src_d = cfg_src;
         dst_d = cfg_dst;
         rem_d = cfg_len;
         pfx_d = cfg_vlen && VLEN_EN;
      end
      if (done) begin
         if (is_rpt) begin
            st_d  = ST_WAIT;
            src_d = c_src0;
            dst_d = c_dst0;
            rem_d = c_len;
            pfx_d = c_vlen && VLEN_EN;
         end else begin
            st_d = ST_OFF;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         src_q <= '0;
         dst_q <= '0;
         rem_q <= '0;
         pfx_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         src_q <= src_d;
         dst_q <= dst_d;
         rem_q <= rem_d;
         pfx_q <= pfx_d;
         irq_q <= done && c_irqen;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_src0  <= '0;
         c_dst0  <= '0;
         c_len   <= '0;
         c_vlen  <= 1'b0;
         c_opt   <= 2'b00;
         c_m8    <= 1'b0;
         c_word  <= 1'b0;
         c_sstep <= STEP_HOLD;
         c_dstep <= STEP_HOLD;
         c_mode  <= XM_SINGLE;
         c_irqen <= 1'b0;
      end else if (load) begin
         c_src0  <= cfg_src;
         c_dst0  <= cfg_dst;
         c_len   <= cfg_len;
         c_vlen  <= cfg_vlen;
         c_opt   <= cfg_vlen_opt;
         c_m8    <= cfg_m8;
         c_word  <= cfg_word;
         c_sstep <= cfg_src_step;
         c_dstep <= cfg_dst_step;
         c_mode  <= cfg_mode;
         c_irqen <= cfg_irq_en;
      end
   end

   assign mem_rd_en   = (st_q == ST_RD);
   assign mem_rd_addr = src_q;
   assign mem_wr_en   = do_wr;
   assign mem_wr_addr = dst_q;
   assign mem_wr_data = mem_rd_data;
   assign mem_wr_word = c_word;
   assign armed       = (st_q != ST_OFF);
   assign busy        = (st_q == ST_RD) || (st_q == ST_WR);
   assign irq         = irq_q;

endmodule

// File: rtl/vlen_dma_chan_chk.sv
module vlen_dma_chan_chk (
   input logic clk,
   input logic rst_n,
   input logic arm,
   input logic armed,
   input logic irq,
   input logic irq_en_q,
   input logic mem_rd_en,
   input logic mem_wr_en
);

   // R13: a read and a write never share a cycle
   assert_rdwr_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   // R13: every write follows a read in the previous cycle
   assert_wr_after_rd_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(mem_rd_en));

   // R7: the interrupt only appears when enabled at arm time
   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en_q);

   // R12: a disarmed channel touches no memory
   assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (!mem_rd_en && !mem_wr_en));

   // R12: without arm, a disarmed channel stays disarmed whatever trig does
   assert_stay_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm) |=> !armed);

endmodule

bind vlen_dma_chan vlen_dma_chan_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .armed     (armed),
   .irq       (irq),
   .irq_en_q  (c_irqen),
   .mem_rd_en (mem_rd_en),
   .mem_wr_en (mem_wr_en)
);

// File: tb/vlen_dma_chan_tb.sv
module vlen_dma_chan_tb;

   localparam int CLK_P = 10;
   localparam int AW    = 9;
   localparam int LEN_W = 13;
   localparam logic [AW-1:0] SRC0 = 9'h080;
   localparam logic [AW-1:0] DST0 = 9'h140;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             arm = 1'b0;
   logic [AW-1:0]    cfg_src = SRC0;
   logic [AW-1:0]    cfg_dst = DST0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic             cfg_vlen = 1'b0;
   logic [1:0]       cfg_vlen_opt = 2'b00;
   logic             cfg_m8 = 1'b0;
   logic             cfg_word = 1'b0;
   logic [1:0]       cfg_src_step = 2'b01;
   logic [1:0]       cfg_dst_step = 2'b01;
   logic [1:0]       cfg_mode = 2'b00;
   logic             cfg_irq_en = 1'b0;
   logic             trig = 1'b0;
   logic             mem_rd_en;
   logic [AW-1:0]    mem_rd_addr;
   logic [15:0]      mem_rd_data = '0;
   logic             mem_wr_en;
   logic [AW-1:0]    mem_wr_addr;
   logic [15:0]      mem_wr_data;
   logic             mem_wr_word;
   logic             armed, busy, irq;

   logic [7:0] pfx_lo = 8'h00;
   logic [7:0] pfx_hi = 8'h00;

   int n_chk = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   int irq_cnt = 0;
   logic [AW-1:0] la [2048];
   logic [15:0]   ld [2048];
   logic          lw [2048];

   always #(CLK_P/2) clk = ~clk;

   vlen_dma_chan #(.AW(AW), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
      .cfg_vlen(cfg_vlen), .cfg_vlen_opt(cfg_vlen_opt), .cfg_m8(cfg_m8),
      .cfg_word(cfg_word), .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
      .cfg_mode(cfg_mode), .cfg_irq_en(cfg_irq_en), .trig(trig),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_word(mem_wr_word), .armed(armed), .busy(busy), .irq(irq)
   );

   // source memory: prefix bytes at SRC0, a computed pattern elsewhere
   function automatic logic [7:0] rom(input logic [AW-1:0] a);
      if (a == SRC0)         return pfx_lo;
      if (a == SRC0 + 9'd1)  return pfx_hi;
      return (a[7:0] ^ 8'h5A) + {7'b0, a[8]};
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= {rom(mem_rd_addr + 9'd1), rom(mem_rd_addr)};
   end

   always @(posedge clk) begin
      if (rst_n && mem_wr_en && wr_cnt < 2048) begin
         la[wr_cnt] <= mem_wr_addr;
         ld[wr_cnt] <= mem_wr_data;
         lw[wr_cnt] <= mem_wr_word;
      end
      if (rst_n && mem_wr_en) wr_cnt <= wr_cnt + 1;
      if (rst_n && irq)       irq_cnt <= irq_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_trig();
      @(negedge clk) trig = 1'b1;
      @(negedge clk) trig = 1'b0;
   endtask

   task automatic pulse_arm();
      @(negedge clk) arm = 1'b1;
      @(negedge clk) arm = 1'b0;
   endtask

   function automatic int exp_total(input logic vlen, input logic [1:0] opt, input logic m8,
                                    input logic word, input int len,
                                    input logic [7:0] lo, input logic [7:0] hi);
      int n, raw;
      if (!vlen) return len;
      if (word)    n = int'({hi, lo} & 16'h1FFF);
      else if (m8) n = int'(lo);
      else         n = int'(lo & 8'h7F);
      case (opt)
         2'b00:   raw = n + 1;
         2'b01:   raw = n;
         2'b10:   raw = n + 2;
         default: raw = n + 3;
      endcase
      return (raw > len) ? len : raw;
   endfunction

   function automatic int stepv(input logic [1:0] s);
      if (s == 2'b01) return 1;
      if (s == 2'b10) return -1;
      return 0;
   endfunction

   task automatic run(input string req, input logic [1:0] mode, input logic word,
                      input logic [1:0] ss, input logic [1:0] ds, input logic vlen,
                      input logic [1:0] opt, input logic m8, input logic irqen,
                      input int len, input logic [7:0] lo, input logic [7:0] hi,
                      input bit do_arm, input bit poke);
      int wb, ib, t, skip, sz, errs;
      logic [AW-1:0] ea, eda;
      logic [15:0] ed, msk;
      longint fa, fe;
      cfg_mode = mode; cfg_word = word; cfg_src_step = ss; cfg_dst_step = ds;
      cfg_vlen = vlen; cfg_vlen_opt = opt; cfg_m8 = m8; cfg_irq_en = irqen;
      cfg_len = LEN_W'(len); cfg_src = SRC0; cfg_dst = DST0;
      pfx_lo = lo; pfx_hi = hi;
      if (do_arm) pulse_arm();
      wb = wr_cnt; ib = irq_cnt;
      t = exp_total(vlen, opt, m8, word, len, lo, hi);
      skip = (vlen && opt == 2'b01) ? 1 : 0;
      sz = word ? 2 : 1;
      if (mode[0]) begin
         pulse_trig();
         if (poke) begin
            @(negedge clk);
            cfg_src = SRC0 + 9'h020; arm = 1'b1; trig = 1'b1;
            @(negedge clk);
            arm = 1'b0; trig = 1'b0; cfg_src = SRC0;
         end
         for (int k = 0; k < 200 && irq_cnt == ib && armed; k++) @(negedge clk);
      end else begin
         for (int k = 0; k < len + 3 && irq_cnt == ib && armed; k++) begin
            pulse_trig();
            repeat (7) @(negedge clk);
         end
      end
      repeat (6) @(negedge clk);
      check(wr_cnt - wb == t, req, "write count", wr_cnt - wb, t);
      errs = 0; fa = 0; fe = 0;
      msk = word ? 16'hFFFF : 16'h00FF;
      for (int i = 0; i < t; i++) begin
         ea  = SRC0 + AW'(stepv(ss) * sz * (i + skip));
         eda = DST0 + AW'(stepv(ds) * sz * i);
         ed  = {rom(ea + 9'd1), rom(ea)} & msk;
         if (la[wb+i] != eda || (ld[wb+i] & msk) != ed || lw[wb+i] != word) begin
            if (errs == 0) begin
               fa = {la[wb+i], ld[wb+i] & msk};
               fe = {eda, ed};
            end
            errs++;
         end
      end
      check(errs == 0, req, "write stream addr/data", fa, fe);
      check(irq_cnt - ib == (irqen ? 1 : 0), "R7", "irq pulses", irq_cnt - ib, irqen ? 1 : 0);
      check(armed == mode[1], "R6", "armed after completion", armed, mode[1]);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      int b;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!armed && !irq && !mem_rd_en && !mem_wr_en, "R1", "reset outputs",
            {armed, irq, mem_rd_en, mem_wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: trigger before arming does nothing
      b = wr_cnt;
      pulse_trig();
      repeat (4) @(negedge clk);
      check(wr_cnt == b && !armed, "R12", "trigger while disarmed", wr_cnt - b, 0);

      // R13 + R1 + R7: exact cycle timing of one unit
      cfg_mode = 2'b00; cfg_word = 1'b0; cfg_src_step = 2'b01; cfg_dst_step = 2'b01;
      cfg_vlen = 1'b0; cfg_len = 13'd1; cfg_irq_en = 1'b1;
      pfx_lo = 8'h3C; pfx_hi = 8'hA5;
      pulse_arm();
      check(armed == 1'b1, "R1", "armed after arm", armed, 1);
      pulse_trig();
      check(mem_rd_en && mem_rd_addr == SRC0 && !mem_wr_en, "R13", "read cycle",
            {mem_rd_en, mem_rd_addr}, {1'b1, SRC0});
      @(negedge clk);
      check(mem_wr_en && mem_wr_addr == DST0 && mem_wr_data[7:0] == 8'h3C, "R13", "write cycle",
            {mem_wr_en, mem_wr_addr, mem_wr_data[7:0]}, {1'b1, DST0, 8'h3C});
      @(negedge clk);
      check(irq == 1'b1 && armed == 1'b0, "R7", "irq one cycle after last write",
            {irq, armed}, 2'b10);
      @(negedge clk);
      check(irq == 1'b0, "R7", "irq is a single pulse", irq, 0);

      // R2 R3 R4 R5: fixed-length sweep over modes, sizes and step codes
      for (int md = 0; md < 2; md++)
         for (int w = 0; w < 2; w++)
            for (int s = 0; s < 3; s++)
               for (int d = 0; d < 3; d++)
                  run(md ? "R3/R4/R5" : "R2/R4/R5", 2'(md), 1'(w), 2'(s), 2'(d),
                      1'b0, 2'b00, 1'b0, 1'b1, 3, 8'h11, 8'h22, 1'b1, 1'b0);

      // R8 R9 R10: variable-length sweep, block mode, cap 9
      for (int o = 0; o < 4; o++)
         for (int p = 0; p < 3; p++)
            for (int v = 0; v < 4; v++) begin
               logic [7:0] lo, hi;
               lo = (p == 0) ? 8'h00 : (p == 1) ? 8'h03 : 8'h85;
               hi = (p == 0) ? 8'hFF : (p == 1) ? 8'hE0 : 8'h00;
               run("R8/R9/R10", 2'b01, 1'(v >> 1), 2'b01, 2'b01, 1'b1, 2'(o),
                   1'(v & 1), 1'b1, 9, lo, hi, 1'b1, 1'b0);
            end

      // R2 R8: variable length in single mode, interrupt disabled
      run("R2/R8", 2'b00, 1'b0, 2'b01, 2'b10, 1'b1, 2'b01, 1'b0, 1'b0, 9, 8'h04, 8'h00, 1'b1, 1'b0);
      run("R2/R8", 2'b00, 1'b1, 2'b10, 2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 9, 8'h02, 8'h40, 1'b1, 1'b0);
      // R10: tight cap
      run("R10", 2'b01, 1'b0, 2'b01, 2'b01, 1'b1, 2'b11, 1'b1, 1'b1, 2, 8'h07, 8'h00, 1'b1, 1'b0);

      // R11: zero-length completions
      run("R11", 2'b01, 1'b0, 2'b01, 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 0, 8'h05, 8'h00, 1'b1, 1'b0);
      run("R11", 2'b00, 1'b0, 2'b01, 2'b01, 1'b0, 2'b00, 1'b0, 1'b1, 0, 8'h05, 8'h00, 1'b1, 1'b0);
      run("R11", 2'b01, 1'b0, 2'b01, 2'b01, 1'b1, 2'b01, 1'b0, 1'b1, 9, 8'h80, 8'h00, 1'b1, 1'b0);
      run("R11", 2'b01, 1'b1, 2'b01, 2'b01, 1'b1, 2'b00, 1'b0, 1'b1, 0, 8'h03, 8'h00, 1'b1, 1'b0);

      // R12: trigger after a non-repeated run disarmed the channel
      b = wr_cnt;
      pulse_trig();
      repeat (6) @(negedge clk);
      check(wr_cnt == b && !armed, "R12", "trigger after disarm", wr_cnt - b, 0);

      // R6: repeated single, two rounds restart at the start addresses
      run("R6", 2'b10, 1'b0, 2'b01, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, 2, 8'h44, 8'h55, 1'b1, 1'b0);
      run("R6", 2'b10, 1'b0, 2'b01, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, 2, 8'h44, 8'h55, 1'b0, 1'b0);
      // R3 R12 R6: repeated block, mid-block trigger and arm are ignored
      run("R3/R12", 2'b11, 1'b1, 2'b01, 2'b01, 1'b1, 2'b10, 1'b0, 1'b1, 9, 8'h03, 8'h00, 1'b1, 1'b1);
      run("R6/R8", 2'b11, 1'b1, 2'b01, 2'b01, 1'b1, 2'b10, 1'b0, 1'b1, 9, 8'h03, 8'h00, 1'b0, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule